// File: doc/BRIEF.md
# Timed Three-Phase Signal Controller

This block drives one direction of a traffic signal. A Moore state machine steps through green, yellow and red, then back to green, without end. A cycle-counting timer sets how long each phase lasts. The lamps are decoded from the registered phase alone, so exactly one of them is lit in every cycle. The phase register is also brought out as a port.

Each phase length is a parameter. A build-time switch picks between two sets of lengths. The real-time set derives the lengths from the clock frequency: 5 s green, 1 s yellow and 4 s red. The fast set uses short cycle counts that suit simulation. A heartbeat output toggles every half second (or every fast beat count). Its timer runs on its own and never depends on the phase. A synchronous reset restarts both timers and puts the controller in green.

Top module: `sig_phase_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `phase` = 2'b00 (green), only `lamp_grn` lit and `heartbeat` low. The phase timer restarts from zero.
- R2: After reset is released, green holds for exactly GREEN_CYC cycles. It is still shown after GREEN_CYC-1 cycles and turns to yellow (`phase` = 2'b01) after GREEN_CYC cycles.
- R3: Yellow holds for exactly YELLOW_CYC cycles, then turns to red (`phase` = 2'b10).
- R4: Red holds for exactly RED_CYC cycles, then returns to green, and the green, yellow, red order repeats with the same timing on every pass.
- R5: `phase` never takes 2'b11. The lamps are one-hot and match the phase: {red,yel,grn} = 001 for green, 010 for yellow and 100 for red.
- R6: A reset asserted in any phase returns the controller to green with a full green interval. This includes the cycle in which a phase would expire, and in that cycle reset wins.
- R7: `heartbeat` toggles every BEAT_CYC cycles, counted from reset, whatever the phase transitions are doing.
- R8: With FAST=0 the lengths are GREEN_CYC=5·CLK_HZ, YELLOW_CYC=CLK_HZ, RED_CYC=4·CLK_HZ and BEAT_CYC=CLK_HZ/2. With FAST=1 they are the FAST_* parameters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lamp_red | output | 1 | Red lamp |
| lamp_yel | output | 1 | Yellow lamp |
| lamp_grn | output | 1 | Green lamp |
| heartbeat | output | 1 | Free-running half-period toggle |
| phase | output | 2 | Registered phase: 00 green, 01 yellow, 10 red |

## Verification
Two functions can fall in the same cycle: a reset and the expiry of a phase. The bench provokes this by raising reset exactly on the edge where green's timer would run out. The result counts as correct only if the controller stays green and then holds green for a full fresh interval. A second overlap is built into the fast settings: the heartbeat's second toggle lands on the same edge as the green-to-yellow change, so a cycle-by-cycle scan checks that neither disturbs the other. An instance with real-time derivation and a tiny clock frequency checks the derived lengths over three full rounds.

// File: rtl/sig_phase_ctrl.sv
module sig_phase_ctrl #(
  parameter int CLK_HZ      = 25_000_000,
  parameter bit FAST        = 1'b0,
  parameter int FAST_GREEN  = 8,
  parameter int FAST_YELLOW = 2,
  parameter int FAST_RED    = 6,
  parameter int FAST_BEAT   = 3
) (
  input  logic       clk,
  input  logic       rst,
  output logic       lamp_red,
  output logic       lamp_yel,
  output logic       lamp_grn,
  output logic       heartbeat,
  output logic [1:0] phase
);
  localparam int GREEN_CYC  = FAST ? FAST_GREEN  : 5 * CLK_HZ;
  localparam int YELLOW_CYC = FAST ? FAST_YELLOW : CLK_HZ;
  localparam int RED_CYC    = FAST ? FAST_RED    : 4 * CLK_HZ;
  localparam int BEAT_CYC   = FAST ? FAST_BEAT   : CLK_HZ / 2;
  localparam int MAX_GY     = (GREEN_CYC > YELLOW_CYC) ? GREEN_CYC : YELLOW_CYC;
  localparam int MAX_CYC    = (MAX_GY > RED_CYC) ? MAX_GY : RED_CYC;
  localparam int TW         = $clog2(MAX_CYC + 1);
  localparam int BW         = $clog2(BEAT_CYC + 1);

  localparam logic [1:0] PH_GREEN  = 2'd0;
  localparam logic [1:0] PH_YELLOW = 2'd1;
  localparam logic [1:0] PH_RED    = 2'd2;

  logic [TW-1:0] tmr;
  logic [TW-1:0] last_tick;
  logic [1:0]    nxt;
  logic          expire;
  logic [BW-1:0] beat_cnt;

  always_comb begin
    case (phase)
      PH_GREEN:  begin last_tick = TW'(GREEN_CYC - 1);  nxt = PH_YELLOW; end
      PH_YELLOW: begin last_tick = TW'(YELLOW_CYC - 1); nxt = PH_RED;    end
      PH_RED:    begin last_tick = TW'(RED_CYC - 1);    nxt = PH_GREEN;  end
      default:   begin last_tick = '0;                  nxt = PH_GREEN;  end
    endcase
  end

  assign expire = (phase == 2'b11) || (tmr == last_tick);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_GREEN;
      tmr   <= '0;
    end else if (expire) begin
      phase <= nxt;
      tmr   <= '0;
    end else begin
      tmr   <= tmr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_cnt  <= '0;
      heartbeat <= 1'b0;
    end else if (beat_cnt == BW'(BEAT_CYC - 1)) begin
      beat_cnt  <= '0;
      heartbeat <= ~heartbeat;
    end else begin
      beat_cnt  <= beat_cnt + 1'b1;
    end
  end

  assign lamp_grn = (phase == PH_GREEN);
  assign lamp_yel = (phase == PH_YELLOW);
  assign lamp_red = (phase == PH_RED);
endmodule

// File: rtl/sig_phase_chk.sv
module sig_phase_chk #(
  parameter int GC = 8,
  parameter int YC = 2,
  parameter int RC = 6,
  parameter int HB = 3
) (
  input logic       clk,
  input logic       rst,
  input logic       lamp_red,
  input logic       lamp_yel,
  input logic       lamp_grn,
  input logic       heartbeat,
  input logic [1:0] phase
);
  function automatic int dur(input logic [1:0] p);
    case (p)
      2'd0:    return GC;
      2'd1:    return YC;
      2'd2:    return RC;
      default: return 0;
    endcase
  endfunction

  logic [1:0] last_ph;
  logic       last_hb;
  int         dwell;
  int         hdwell;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_ph <= 2'd0;
      last_hb <= 1'b0;
      dwell   <= 0;
      hdwell  <= 0;
    end else begin
      last_ph <= phase;
      last_hb <= heartbeat;
      dwell   <= (phase != last_ph) ? 1 : dwell + 1;
      hdwell  <= (heartbeat != last_hb) ? 1 : hdwell + 1;
    end
  end

  assert_reset_green_R1: assert property (@(posedge clk)
    rst |=> (phase == 2'd0 && !heartbeat));

  assert_phase_order_R4: assert property (@(posedge clk) disable iff (rst)
    (phase != last_ph) |-> (phase == ((last_ph == 2'd2) ? 2'd0 : last_ph + 2'd1)));

  assert_exact_dwell_R2: assert property (@(posedge clk) disable iff (rst)
    (phase != last_ph) |-> (dwell == dur(last_ph)));

  assert_no_overstay_R3: assert property (@(posedge clk) disable iff (rst)
    dwell <= dur(last_ph));

  assert_legal_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    phase != 2'b11 && $countones({lamp_red, lamp_yel, lamp_grn}) == 1);

  assert_beat_period_R7: assert property (@(posedge clk) disable iff (rst)
    (heartbeat != last_hb) |-> (hdwell == HB));
endmodule

bind sig_phase_ctrl sig_phase_chk #(
  .GC(GREEN_CYC), .YC(YELLOW_CYC), .RC(RED_CYC), .HB(BEAT_CYC)
) u_chk (
  .clk(clk), .rst(rst), .lamp_red(lamp_red), .lamp_yel(lamp_yel),
  .lamp_grn(lamp_grn), .heartbeat(heartbeat), .phase(phase)
);

// File: tb/sim_sig_phase_ctrl.sv
module sim_sig_phase_ctrl;
  localparam int G = 6, Y = 2, R = 4, H = 3;
  localparam int HZ1 = 4;
  localparam int G1 = 5 * HZ1, Y1 = HZ1, R1C = 4 * HZ1, H1 = HZ1 / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic r0, y0, g0, hb0, r1, y1, g1, hb1;
  logic [1:0] ph0, ph1;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sig_phase_ctrl #(.CLK_HZ(125_000_000), .FAST(1'b1), .FAST_GREEN(G),
                   .FAST_YELLOW(Y), .FAST_RED(R), .FAST_BEAT(H)) u0 (
    .clk(clk), .rst(rst), .lamp_red(r0), .lamp_yel(y0), .lamp_grn(g0),
    .heartbeat(hb0), .phase(ph0));

  sig_phase_ctrl #(.CLK_HZ(HZ1), .FAST(1'b0)) u1 (
    .clk(clk), .rst(rst), .lamp_red(r1), .lamp_yel(y1), .lamp_grn(g1),
    .heartbeat(hb1), .phase(ph1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(2);
    rst = 1'b0;
  endtask

  function automatic logic [1:0] exp_phase(input int t, input int gc, input int yc, input int rc);
    int m = t % (gc + yc + rc);
    if (m < gc) return 2'd0;
    if (m < gc + yc) return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [2:0] lamps_of(input logic [1:0] p);
    case (p)
      2'd0: return 3'b001;
      2'd1: return 3'b010;
      default: return 3'b100;
    endcase
  endfunction

  task automatic t_reset_state();
    do_reset();
    chk(ph0 == 2'd0, "R1 phase", ph0, 0);
    chk({r0, y0, g0} == 3'b001, "R1 lamps", {r0, y0, g0}, 1);
    chk(hb0 == 1'b0, "R1 heartbeat", hb0, 0);
  endtask

  task automatic t_boundaries();
    do_reset();
    step(G - 1);
    chk(ph0 == 2'd0, "R2 green at G-1", ph0, 0);
    step(1);
    chk(ph0 == 2'd1, "R2 yellow at G", ph0, 1);
    step(Y - 1);
    chk(ph0 == 2'd1, "R3 yellow at Y-1", ph0, 1);
    step(1);
    chk(ph0 == 2'd2, "R3 red at Y", ph0, 2);
    step(R - 1);
    chk(ph0 == 2'd2, "R4 red at R-1", ph0, 2);
    step(1);
    chk(ph0 == 2'd0, "R4 green again", ph0, 0);
  endtask

  task automatic t_scan();
    do_reset();
    for (int t = 0; t <= 3 * (G1 + Y1 + R1C); t++) begin
      logic [1:0] e0, e1;
      e0 = exp_phase(t, G, Y, R);
      e1 = exp_phase(t, G1, Y1, R1C);
      chk(ph0 == e0, "R4 scan phase", ph0, e0);
      chk({r0, y0, g0} == lamps_of(e0), "R5 lamps", {r0, y0, g0}, lamps_of(e0));
      chk(hb0 == ((t / H) % 2), "R7 heartbeat", hb0, (t / H) % 2);
      chk(ph1 == e1, "R8 real-time phase", ph1, e1);
      chk({r1, y1, g1} == lamps_of(e1), "R5 lamps real-time", {r1, y1, g1}, lamps_of(e1));
      chk(hb1 == ((t / H1) % 2), "R8 real-time heartbeat", hb1, (t / H1) % 2);
      step(1);
    end
  endtask

  task automatic t_mid_reset();
    do_reset();
    step(G + 1);
    chk(ph0 == 2'd1, "R6 in yellow before reset", ph0, 1);
    rst = 1'b1;
    step(1);
    rst = 1'b0;
    chk(ph0 == 2'd0, "R6 green after mid reset", ph0, 0);
    chk(hb0 == 1'b0, "R6 heartbeat cleared", hb0, 0);
    step(G - 1);
    chk(ph0 == 2'd0, "R6 full green after reset", ph0, 0);
    step(1);
    chk(ph0 == 2'd1, "R6 yellow after fresh green", ph0, 1);
  endtask

  task automatic t_reset_at_expiry();
    do_reset();
    step(G - 1);
    rst = 1'b1;
    step(1);
    rst = 1'b0;
    chk(ph0 == 2'd0, "R6 reset beats expiry", ph0, 0);
    step(G - 1);
    chk(ph0 == 2'd0, "R6 fresh timer after collision", ph0, 0);
    step(1);
    chk(ph0 == 2'd1, "R6 yellow after collision", ph0, 1);
  endtask

  initial begin
    t_reset_state();
    t_boundaries();
    t_scan();
    t_mid_reset();
    t_reset_at_expiry();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule